// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between an on-chip requester and an external 16-bit asynchronous static RAM with a 20-bit word address. It takes one word request at a time from a valid/ready port. Each request carries an address, write data, a two-bit lane mask and a write flag. The block turns the request into a registered pin sequence. The sequence drives two device selects of opposite polarity, a write strobe, an output-enable strobe and two byte-lane enables. The bidirectional data bus is driven through separate output-data and drive-enable signals. Read data comes back with a one-cycle valid pulse.

Every analog timing rule of the RAM is expressed as a whole number of clock cycles through parameters. These rules cover the read access window, the write pulse width, the bus release time after a read and the settling delay after power-on. Elaboration checks reject cycle counts that fall short of the device's minimum times at the stated clock period. No request is taken until the power-on delay has run out.

Top module: `asram_ctrl`

## Requirements
- R1: Whenever no access is in progress (including reset and power-on wait), the device is deselected (`ram_sel_n`=1, `ram_sel_p`=0), `ram_wr_n`=1, `ram_rd_n`=1, both lane enables are 1 and `ram_dq_oe`=0.
- R2: After reset is released, `req_ready` stays 0 for exactly PWRUP_CYC clock edges and rises after edge PWRUP_CYC+1. A request presented during that time is ignored: no write strobe occurs.
- R3: A write runs as one setup cycle (selected, data driven, `ram_wr_n`=1), then `ram_wr_n`=0 for exactly WE_CYC cycles, then one hold cycle (`ram_wr_n`=1, data still driven, still selected). Address and data do not change while the strobe is low.
- R4: Lane mask bit 0 set drives `ram_lane_lo_n`=0 (data bits 7:0) and bit 1 set drives `ram_lane_hi_n`=0 (bits 15:8) during the access. A lane whose mask bit is 0 is not written, so its byte in the RAM keeps its old value.
- R5: A read holds the device selected with `ram_rd_n`=0 and `ram_wr_n`=1 for exactly RD_CYC cycles. The bus is captured at the end of the last of these cycles. `rsp_valid` is 1 for exactly one cycle, the cycle after the window.
- R6: In `rsp_rdata`, the byte of a lane whose mask bit is 0 reads as zero.
- R7: After a read, TA_CYC cycles follow with the device deselected, `ram_dq_oe`=0 and `req_ready`=0. The controller never raises `ram_dq_oe` fewer than TA_CYC cycles after `ram_rd_n` returned high.
- R8: `ram_wr_n` and `ram_rd_n` are never both 0, and `ram_dq_oe` is never 1 while `ram_rd_n` is 0.
- R9: A request is taken only on an edge where `req_valid` and `req_ready` are both 1. `req_ready` returns to 1 WE_CYC+3 cycles after a write is taken and RD_CYC+TA_CYC+1 cycles after a read is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Write data |
| req_mask | input | 2 | Lane mask, active high (bit 0 low byte) |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | DW | Read data, disabled lanes zero |
| ram_addr | output | AW | Address pins |
| ram_sel_n | output | 1 | Active-low device select |
| ram_sel_p | output | 1 | Active-high device select |
| ram_wr_n | output | 1 | Write strobe, active low |
| ram_rd_n | output | 1 | Output enable, active low |
| ram_lane_lo_n | output | 1 | Low byte lane enable, active low |
| ram_lane_hi_n | output | 1 | High byte lane enable, active low |
| ram_dq_o | output | DW | Data to the bus |
| ram_dq_oe | output | 1 | Drive enable for the data bus |
| ram_dq_i | input | DW | Data from the bus |

## Verification
The bench builds the block with PWRUP_CYC=40, RD_CYC=3, WE_CYC=2 and TA_CYC=2 at an 8 ns period. Multi-cycle strobe, access and release windows therefore exercise every counter past its first step, and the power-on wait stays short enough to measure to the exact edge. The bench's RAM model presents valid data only once output enable has been low for RD_CYC-1 edges, and it puts a fill pattern on disabled lanes. An early capture or a missing lane mask therefore shows up in the returned data.

// File: rtl/asram_pkg.sv
package asram_pkg;

   // device minimum times in picoseconds
   localparam int unsigned T_ACC_PS   = 10000; // address / select to valid data
   localparam int unsigned T_WPULSE_PS = 7000; // write strobe low time
   localparam int unsigned T_RELEASE_PS = 5000; // bus release after output enable rises
   localparam int unsigned T_CYCLE_PS = 10000; // minimum access cycle
   localparam int unsigned LANE_W     = 8;

   typedef enum logic [2:0] {
      ST_PWRUP  = 3'd0,
      ST_IDLE   = 3'd1,
      ST_WSETUP = 3'd2,
      ST_WPULSE = 3'd3,
      ST_WHOLD  = 3'd4,
      ST_RACC   = 3'd5,
      ST_RTURN  = 3'd6
   } asram_state_e;

   // internal strobes, all active high
   typedef struct packed {
      logic sel;
      logic wr;
      logic rd;
      logic drive;
   } asram_strobe_t;

   function automatic int unsigned cycles_for(input int unsigned ps, input int unsigned clk_ps);
      return (ps + clk_ps - 1) / clk_ps;
   endfunction

   function automatic asram_strobe_t strobe_of(input asram_state_e st);
      asram_strobe_t s;
      s = '0;
      unique case (st)
         ST_WSETUP: begin s.sel = 1'b1; s.drive = 1'b1; end
         ST_WPULSE: begin s.sel = 1'b1; s.drive = 1'b1; s.wr = 1'b1; end
         ST_WHOLD:  begin s.sel = 1'b1; s.drive = 1'b1; end
         ST_RACC:   begin s.sel = 1'b1; s.rd = 1'b1; end
         default:   s = '0;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/asram_pwrup.sv
module asram_pwrup #(
   parameter int unsigned PWRUP_CYC = 12500
) (
   input  logic clk,
   input  logic rst_n,
   output logic done
);
   localparam int unsigned CW = (PWRUP_CYC < 2) ? 1 : $clog2(PWRUP_CYC + 1);

   logic [CW-1:0] remain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         remain_q <= CW'(PWRUP_CYC);
      end else if (remain_q != '0) begin
         remain_q <= remain_q - 1'b1;
      end
   end

   assign done = (remain_q == '0);

   // once released, access stays allowed until the next reset
   p_done_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> done);

endmodule

// File: rtl/asram_seq.sv
module asram_seq
   import asram_pkg::*;
#(
   parameter int unsigned RD_CYC = 2,
   parameter int unsigned WE_CYC = 1,
   parameter int unsigned TA_CYC = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pwr_done,
   input  logic          req_valid,
   input  logic          req_write,
   output logic          req_ready,
   output logic          accept,
   output logic          sample,
   output asram_strobe_t strobe_d
);
   localparam int unsigned MAX_AB = (RD_CYC > WE_CYC) ? RD_CYC : WE_CYC;
   localparam int unsigned MAX_C  = (MAX_AB > TA_CYC) ? MAX_AB : TA_CYC;
   localparam int unsigned CW     = (MAX_C < 2) ? 1 : $clog2(MAX_C);

   asram_state_e  state_q, state_d;
   logic [CW-1:0] cnt_q, cnt_d;

   assign req_ready = (state_q == ST_IDLE);
   assign accept    = req_ready && req_valid;
   assign sample    = (state_q == ST_RACC) && (cnt_q == '0);

   always_comb begin
      state_d = state_q;
      cnt_d   = cnt_q;
      unique case (state_q)
         ST_PWRUP: begin
            if (pwr_done) state_d = ST_IDLE;
         end
         ST_IDLE: begin
            if (req_valid) begin
               if (req_write) begin
                  state_d = ST_WSETUP;
               end else begin
                  state_d = ST_RACC;
                  cnt_d   = CW'(RD_CYC - 1);
               end
            end
         end
         ST_WSETUP: begin
            state_d = ST_WPULSE;
            cnt_d   = CW'(WE_CYC - 1);
         end
         ST_WPULSE: begin
            if (cnt_q == '0) state_d = ST_WHOLD;
            else             cnt_d   = cnt_q - 1'b1;
         end
         ST_WHOLD: begin
            state_d = ST_IDLE;
         end
         ST_RACC: begin
            if (cnt_q == '0) begin
               state_d = ST_RTURN;
               cnt_d   = CW'(TA_CYC - 1);
            end else begin
               cnt_d = cnt_q - 1'b1;
            end
         end
         ST_RTURN: begin
            if (cnt_q == '0) state_d = ST_IDLE;
            else             cnt_d   = cnt_q - 1'b1;
         end
         default: begin
            state_d = ST_PWRUP;
            cnt_d   = '0;
         end
      endcase
   end

   assign strobe_d = strobe_of(state_d);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_PWRUP;
         cnt_q   <= '0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
      end
   end

   // no access may leave the power-on wait before the timer has expired
   p_wait_for_power_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_PWRUP && !pwr_done) |=> (state_q == ST_PWRUP));

   // a capture is always followed by the release window, never by a new access
   p_sample_then_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
      sample |=> (state_q == ST_RTURN));

endmodule

// File: rtl/asram_pins.sv
module asram_pins
   import asram_pkg::*;
#(
   parameter int unsigned AW     = 20,
   parameter int unsigned DW     = 16,
   parameter int unsigned WE_CYC = 1,
   parameter int unsigned TA_CYC = 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 accept,
   input  logic [AW-1:0]        req_addr,
   input  logic [DW-1:0]        req_wdata,
   input  logic [DW/LANE_W-1:0] req_mask,
   input  asram_strobe_t        strobe_d,
   input  logic                 sample,
   input  logic [DW-1:0]        ram_dq_i,
   output logic                 rsp_valid,
   output logic [DW-1:0]        rsp_rdata,
   output logic [AW-1:0]        ram_addr,
   output logic                 ram_sel_n,
   output logic                 ram_sel_p,
   output logic                 ram_wr_n,
   output logic                 ram_rd_n,
   output logic [DW/LANE_W-1:0] ram_lane_n,
   output logic [DW-1:0]        ram_dq_o,
   output logic                 ram_dq_oe
);
   localparam int unsigned LANES = DW / LANE_W;
   localparam int unsigned MAXW  = (WE_CYC > TA_CYC) ? WE_CYC : TA_CYC;
   localparam int unsigned KW    = $clog2(MAXW + 2) + 1;

   logic [AW-1:0]    addr_q;
   logic [DW-1:0]    wdata_q;
   logic [LANES-1:0] mask_q;
   logic [LANES-1:0] mask_src;

   assign mask_src = accept ? req_mask : mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         wdata_q <= '0;
         mask_q  <= '0;
      end else if (accept) begin
         addr_q  <= req_addr;
         wdata_q <= req_wdata;
         mask_q  <= req_mask;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ram_sel_n <= 1'b1;
         ram_sel_p <= 1'b0;
         ram_wr_n  <= 1'b1;
         ram_rd_n  <= 1'b1;
         ram_dq_oe <= 1'b0;
         rsp_valid <= 1'b0;
      end else begin
         ram_sel_n <= !strobe_d.sel;
         ram_sel_p <= strobe_d.sel;
         ram_wr_n  <= !strobe_d.wr;
         ram_rd_n  <= !strobe_d.rd;
         ram_dq_oe <= strobe_d.drive;
         rsp_valid <= sample;
      end
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ram_lane_n[g]                  <= 1'b1;
            rsp_rdata[g*LANE_W +: LANE_W]  <= '0;
         end else begin
            ram_lane_n[g] <= !(strobe_d.sel && mask_src[g]);
            if (sample) begin
               rsp_rdata[g*LANE_W +: LANE_W] <= mask_q[g] ? ram_dq_i[g*LANE_W +: LANE_W]
                                                           : '0;
            end
         end
      end
   end

   assign ram_addr = addr_q;
   assign ram_dq_o = wdata_q;

   // checker state: strobe low time and time since output enable returned high
   logic [KW-1:0] wr_low_cnt;
   logic [KW-1:0] rd_off_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_low_cnt <= '0;
         rd_off_cnt <= '1;
      end else begin
         if (!ram_wr_n) wr_low_cnt <= (wr_low_cnt == '1) ? wr_low_cnt : wr_low_cnt + 1'b1;
         else           wr_low_cnt <= '0;
         if (!ram_rd_n) rd_off_cnt <= '0;
         else           rd_off_cnt <= (rd_off_cnt == '1) ? rd_off_cnt : rd_off_cnt + 1'b1;
      end
   end

   p_strobe_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(!ram_wr_n && !ram_rd_n));

   p_no_contention_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(ram_dq_oe && !ram_rd_n));

   p_drive_lead_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ram_wr_n) |-> $past(ram_dq_oe));

   p_drive_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ram_wr_n) |-> (ram_dq_oe && !ram_sel_n && ram_sel_p));

   p_addr_data_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !ram_wr_n |-> ($stable(ram_addr) && $stable(ram_dq_o) && $stable(ram_lane_n)));

   p_pulse_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ram_wr_n) |-> (wr_low_cnt == KW'(WE_CYC)));

   p_rsp_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   p_release_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ram_dq_oe) |-> (rd_off_cnt >= KW'(TA_CYC)));

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
   import asram_pkg::*;
#(
   parameter int unsigned AW        = 20,
   parameter int unsigned DW        = 16,
   parameter int unsigned CLK_PS    = 8000,
   parameter int unsigned PWRUP_CYC = 12500,
   parameter int unsigned RD_CYC    = 2,
   parameter int unsigned WE_CYC    = 1,
   parameter int unsigned TA_CYC    = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic          req_write,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   input  logic [1:0]    req_mask,
   output logic          rsp_valid,
   output logic [DW-1:0] rsp_rdata,
   output logic [AW-1:0] ram_addr,
   output logic          ram_sel_n,
   output logic          ram_sel_p,
   output logic          ram_wr_n,
   output logic          ram_rd_n,
   output logic          ram_lane_lo_n,
   output logic          ram_lane_hi_n,
   output logic [DW-1:0] ram_dq_o,
   output logic          ram_dq_oe,
   input  logic [DW-1:0] ram_dq_i
);
   localparam int unsigned LANES   = DW / LANE_W;
   localparam int unsigned MIN_RD  = cycles_for(T_ACC_PS, CLK_PS);
   localparam int unsigned MIN_WE  = cycles_for(T_WPULSE_PS, CLK_PS);
   localparam int unsigned MIN_TA  = cycles_for(T_RELEASE_PS, CLK_PS);
   localparam int unsigned MIN_CYC = cycles_for(T_CYCLE_PS, CLK_PS);

   if (DW != 2 * LANE_W) begin : g_bad_width
      $error("asram_ctrl: data width must be two byte lanes");
   end
   if (AW < 1 || CLK_PS < 1 || PWRUP_CYC < 1) begin : g_bad_basic
      $error("asram_ctrl: address width, clock period and power-on delay must be nonzero");
   end
   if (RD_CYC < MIN_RD || RD_CYC < MIN_CYC || RD_CYC < 1) begin : g_bad_rd
      $error("asram_ctrl: read window shorter than the access time");
   end
   if (WE_CYC < MIN_WE || WE_CYC + 2 < MIN_CYC || WE_CYC < 1) begin : g_bad_we
      $error("asram_ctrl: write pulse or write cycle too short");
   end
   if (TA_CYC < MIN_TA || TA_CYC < 1) begin : g_bad_ta
      $error("asram_ctrl: bus release window too short");
   end

   logic          pwr_done;
   logic          accept;
   logic          sample;
   asram_strobe_t strobe_d;
   logic [LANES-1:0] lane_n;

   asram_pwrup #(.PWRUP_CYC(PWRUP_CYC)) u_pwrup (
      .clk   (clk),
      .rst_n (rst_n),
      .done  (pwr_done)
   );

   asram_seq #(.RD_CYC(RD_CYC), .WE_CYC(WE_CYC), .TA_CYC(TA_CYC)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .pwr_done  (pwr_done),
      .req_valid (req_valid),
      .req_write (req_write),
      .req_ready (req_ready),
      .accept    (accept),
      .sample    (sample),
      .strobe_d  (strobe_d)
   );

   asram_pins #(.AW(AW), .DW(DW), .WE_CYC(WE_CYC), .TA_CYC(TA_CYC)) u_pins (
      .clk        (clk),
      .rst_n      (rst_n),
      .accept     (accept),
      .req_addr   (req_addr),
      .req_wdata  (req_wdata),
      .req_mask   (req_mask),
      .strobe_d   (strobe_d),
      .sample     (sample),
      .ram_dq_i   (ram_dq_i),
      .rsp_valid  (rsp_valid),
      .rsp_rdata  (rsp_rdata),
      .ram_addr   (ram_addr),
      .ram_sel_n  (ram_sel_n),
      .ram_sel_p  (ram_sel_p),
      .ram_wr_n   (ram_wr_n),
      .ram_rd_n   (ram_rd_n),
      .ram_lane_n (lane_n),
      .ram_dq_o   (ram_dq_o),
      .ram_dq_oe  (ram_dq_oe)
   );

   assign ram_lane_lo_n = lane_n[0];
   assign ram_lane_hi_n = lane_n[1];

   p_idle_deselect_r1: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (ram_sel_n && !ram_sel_p && ram_wr_n && ram_rd_n && !ram_dq_oe
                     && ram_lane_lo_n && ram_lane_hi_n));

   p_power_block_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_done |-> (!req_ready && ram_wr_n && ram_sel_n));

endmodule

// File: tb/tb_asram_ctrl.sv
module tb_asram_ctrl;
   localparam int unsigned AW    = 20;
   localparam int unsigned DW    = 16;
   localparam int unsigned PWR   = 40;
   localparam int unsigned RD    = 3;
   localparam int unsigned WE    = 2;
   localparam int unsigned TA    = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic          req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic [1:0]    req_mask = '0;
   logic          rsp_valid;
   logic [DW-1:0] rsp_rdata;
   logic [AW-1:0] ram_addr;
   logic          ram_sel_n, ram_sel_p, ram_wr_n, ram_rd_n;
   logic          ram_lane_lo_n, ram_lane_hi_n;
   logic [DW-1:0] ram_dq_o;
   logic          ram_dq_oe;
   logic [DW-1:0] ram_dq_i;

   int unsigned n_tests = 0;
   int unsigned n_fail  = 0;

   always #4 clk = ~clk;

   asram_ctrl #(.AW(AW), .DW(DW), .CLK_PS(8000), .PWRUP_CYC(PWR),
                .RD_CYC(RD), .WE_CYC(WE), .TA_CYC(TA)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .req_mask(req_mask), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .ram_addr(ram_addr), .ram_sel_n(ram_sel_n), .ram_sel_p(ram_sel_p),
      .ram_wr_n(ram_wr_n), .ram_rd_n(ram_rd_n), .ram_lane_lo_n(ram_lane_lo_n),
      .ram_lane_hi_n(ram_lane_hi_n), .ram_dq_o(ram_dq_o), .ram_dq_oe(ram_dq_oe),
      .ram_dq_i(ram_dq_i)
   );

   // ---------------- RAM model and reference ----------------
   logic [15:0] model_mem [logic [19:0]];
   logic [15:0] ref_mem   [logic [19:0]];
   int unsigned rd_low_edges = 0;
   logic        pend = 1'b0;
   logic [19:0] p_addr;
   logic [15:0] p_data;
   logic        p_lo, p_hi;

   function automatic logic [15:0] model_get(input logic [19:0] a);
      return model_mem.exists(a) ? model_mem[a] : 16'h0000;
   endfunction

   function automatic logic [15:0] ref_get(input logic [19:0] a);
      return ref_mem.exists(a) ? ref_mem[a] : 16'h0000;
   endfunction

   function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] nw,
                                         input logic [1:0] m);
      return {m[1] ? nw[15:8] : old[15:8], m[0] ? nw[7:0] : old[7:0]};
   endfunction

   function automatic logic [15:0] expect_rd(input logic [15:0] v, input logic [1:0] m);
      return {m[1] ? v[15:8] : 8'h00, m[0] ? v[7:0] : 8'h00};
   endfunction

   always @(posedge clk) begin
      if (!ram_sel_n && ram_sel_p && !ram_rd_n) rd_low_edges <= rd_low_edges + 1;
      else                                      rd_low_edges <= 0;
      if (!ram_sel_n && ram_sel_p && !ram_wr_n) begin
         pend   <= 1'b1;
         p_addr <= ram_addr;
         p_data <= ram_dq_o;
         p_lo   <= !ram_lane_lo_n;
         p_hi   <= !ram_lane_hi_n;
      end else if (pend && ram_wr_n) begin
         model_mem[p_addr] = merge(model_get(p_addr), p_data, {p_hi, p_lo});
         pend <= 1'b0;
      end
   end

   always @* begin
      ram_dq_i = 16'h5A5A;
      if (!ram_sel_n && ram_sel_p && !ram_rd_n && ram_wr_n && rd_low_edges >= RD - 1) begin
         ram_dq_i[7:0]  = !ram_lane_lo_n ? model_get(ram_addr)[7:0]  : 8'hA5;
         ram_dq_i[15:8] = !ram_lane_hi_n ? model_get(ram_addr)[15:8] : 8'hA5;
      end
   end

   // ---------------- checking helpers ----------------
   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic take(input bit wr, input logic [19:0] a, input logic [15:0] d,
                       input logic [1:0] m);
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic do_write(input logic [19:0] a, input logic [15:0] d, input logic [1:0] m);
      take(1'b1, a, d, m);
      // k = 1: setup cycle
      chk(!ram_sel_n && ram_sel_p && ram_wr_n && ram_dq_oe, "R3 setup",
          {ram_sel_n, ram_sel_p, ram_wr_n, ram_dq_oe}, 4'b0111);
      chk({ram_lane_hi_n, ram_lane_lo_n} == ~m, "R4 lanes setup",
          {ram_lane_hi_n, ram_lane_lo_n}, ~m);
      for (int k = 0; k < WE; k++) begin
         @(negedge clk);
         chk(!ram_wr_n && ram_dq_oe && ram_rd_n, "R3 pulse", {ram_wr_n, ram_dq_oe, ram_rd_n}, 3'b011);
         chk(ram_addr == a && ram_dq_o == d, "R3 addr/data", {ram_addr[15:0], ram_dq_o}, {a[15:0], d});
         chk({ram_lane_hi_n, ram_lane_lo_n} == ~m, "R4 lanes pulse",
             {ram_lane_hi_n, ram_lane_lo_n}, ~m);
      end
      @(negedge clk);
      chk(ram_wr_n && ram_dq_oe && !ram_sel_n, "R3 hold", {ram_wr_n, ram_dq_oe, ram_sel_n}, 3'b110);
      @(negedge clk);
      chk(req_ready, "R9 write ready", req_ready, 1);
      chk(ram_sel_n && !ram_sel_p && !ram_dq_oe && ram_lane_lo_n && ram_lane_hi_n, "R1 idle after write",
          {ram_sel_n, ram_sel_p, ram_dq_oe, ram_lane_lo_n, ram_lane_hi_n}, 5'b10011);
      ref_mem[a] = merge(ref_get(a), d, m);
   endtask

   task automatic do_read(input logic [19:0] a, input logic [1:0] m);
      logic [15:0] exp;
      exp = expect_rd(ref_get(a), m);
      take(1'b0, a, 16'h0, m);
      for (int k = 0; k < RD; k++) begin
         if (k > 0) @(negedge clk);
         chk(!ram_rd_n && ram_wr_n && !ram_dq_oe && !ram_sel_n && ram_sel_p, "R5 window",
             {ram_rd_n, ram_wr_n, ram_dq_oe, ram_sel_n, ram_sel_p}, 5'b01001);
         chk({ram_lane_hi_n, ram_lane_lo_n} == ~m, "R4 read lanes",
             {ram_lane_hi_n, ram_lane_lo_n}, ~m);
         chk(!req_ready && !rsp_valid, "R9 busy during read", {req_ready, rsp_valid}, 0);
      end
      @(negedge clk);
      chk(rsp_valid, "R5 response pulse", rsp_valid, 1);
      chk(rsp_rdata == exp, "R6 read data", rsp_rdata, exp);
      chk(ram_rd_n && ram_sel_n && !ram_dq_oe && !req_ready, "R7 release start",
          {ram_rd_n, ram_sel_n, ram_dq_oe, req_ready}, 4'b1100);
      for (int k = 1; k < TA; k++) begin
         @(negedge clk);
         chk(!rsp_valid && !req_ready && !ram_dq_oe && ram_sel_n, "R7 release window",
             {rsp_valid, req_ready, ram_dq_oe, ram_sel_n}, 4'b0001);
      end
      @(negedge clk);
      chk(req_ready && !rsp_valid, "R9 read ready", {req_ready, rsp_valid}, 2'b10);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (150000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL R9 watchdog actual=hung expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   // ---------------- stimulus ----------------
   initial begin
      int unsigned seed_sink;
      bit wr_seen;
      seed_sink = $urandom(32'd20240611);
      // request held during power-on wait must be ignored
      req_valid = 1'b1; req_write = 1'b1; req_addr = 20'h00123; req_wdata = 16'hDEAD; req_mask = 2'b11;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(ram_sel_n && !ram_sel_p && ram_wr_n && ram_rd_n && !ram_dq_oe && !rsp_valid && !req_ready,
          "R1 reset state", {ram_sel_n, ram_sel_p, ram_wr_n, ram_rd_n, ram_dq_oe, rsp_valid, req_ready},
          7'b1011000);
      rst_n = 1'b1;
      wr_seen = 1'b0;
      for (int n = 1; n <= PWR + 1; n++) begin
         @(negedge clk);
         if (!ram_wr_n || !ram_sel_n) wr_seen = 1'b1;
         if (n == PWR / 2) req_valid = 1'b0;
         if (n == PWR) chk(!req_ready, "R2 still waiting", req_ready, 0);
         if (n == PWR + 1) chk(req_ready, "R2 ready after wait", req_ready, 1);
      end
      chk(!wr_seen, "R2 early request ignored", wr_seen, 0);
      do_read(20'h00123, 2'b11);
      chk(rsp_rdata == 16'h0000, "R2 no write landed", rsp_rdata, 0);

      // directed lane cases
      do_write(20'h00000, 16'h1234, 2'b11);
      do_write(20'hFFFFF, 16'hABCD, 2'b11);
      do_write(20'h00000, 16'hFF55, 2'b01);   // low lane only
      do_write(20'hFFFFF, 16'h77EE, 2'b10);   // high lane only
      do_write(20'h00000, 16'hC3C3, 2'b00);   // no lane: R4 no change
      do_read(20'h00000, 2'b11);
      chk(rsp_rdata == 16'h1255, "R4 low lane merge", rsp_rdata, 16'h1255);
      do_read(20'hFFFFF, 2'b11);
      chk(rsp_rdata == 16'h77CD, "R4 high lane merge", rsp_rdata, 16'h77CD);
      do_read(20'hFFFFF, 2'b01);
      do_read(20'hFFFFF, 2'b10);
      do_read(20'h00000, 2'b00);
      chk(rsp_rdata == 16'h0000, "R6 no lane read", rsp_rdata, 0);
      // read immediately followed by write exercises release window R7
      do_read(20'h00000, 2'b11);
      do_write(20'h00001, 16'h0F0F, 2'b11);
      do_read(20'h00001, 2'b11);

      // constrained random mix
      for (int i = 0; i < 220; i++) begin
         logic [19:0] a;
         logic [1:0]  sel;
         sel = 2'($urandom_range(0, 2));
         a   = (sel == 0) ? 20'h00000 : (sel == 1) ? 20'hFFFF0 : 20'h5A5A0;
         a[3:0] = 4'($urandom_range(0, 15));
         if ($urandom_range(0, 1) == 1)
            do_write(a, 16'($urandom), 2'($urandom_range(0, 3)));
         else
            do_read(a, 2'($urandom_range(0, 3)));
      end

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule